// File: doc/BRIEF.md
# Byte-Lane Bidirectional Bus Transceiver

This block joins an A side and a B side with a 16-bit data path that carries data both ways. The path is cut into two 8-bit lanes. Lane 0 owns bits 7:0 and lane 1 owns bits 15:8. Each lane has, for each direction, its own mode select and its own output enable.

A path whose mode select is high is a pass-through: its output follows its input within the same cycle. A path whose mode select is low shows a register instead. Each direction of each lane has its own register, and every register loads from its input on each rising edge of the one shared clock.

Drive is modelled as a data vector plus a per-bit enable vector on each side, instead of tristate pins. One active-low global enable can switch off every enable bit on both sides at once. The data and control pins are plain signals. Nothing is held back at the edge of the block, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_xcvr16`

## Requirements
- R1: Lane 0 is bits 7:0 and lane 1 is bits 15:8 of every data and enable vector. The controls of one lane (`ab_pass[i]`, `ba_pass[i]`, `ab_en_n[i]`, `ba_en_n[i]`) affect only the bits of lane i.
- R2: While `ab_pass[i]`=1, `b_dout` lane i equals `a_din` lane i in the same cycle, with no clock edge needed.
- R3: While `ba_pass[i]`=1, `a_dout` lane i equals `b_din` lane i in the same cycle.
- R4: While a path's pass bit is 0, its output equals its input as sampled at the most recent rising clock edge.
- R5: While a path's pass bit is 0, a change of its input between clock edges does not change its output.
- R6: The two directions of a lane store separately. `b_din` never changes `b_dout`, and `a_din` never changes `a_dout`.
- R7: `b_oe` lane i is all ones when `ab_en_n[i]`=0 and `all_en_n`=0, and all zeros otherwise.
- R8: `a_oe` lane i is all ones when `ba_en_n[i]`=0 and `all_en_n`=0, and all zeros otherwise.
- R9: While `all_en_n`=1, every bit of `a_oe` and `b_oe` is 0, whatever the per-lane enables are.
- R10: A synchronous reset (`rst`=1 at a rising edge) clears every register to zero.
- R11: A register also loads at rising edges while its path is passing. When the pass bit falls, the output therefore shows the input sampled at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all registers |
| rst | input | 1 | Synchronous reset, active high |
| all_en_n | input | 1 | Global output enable, active low |
| ab_pass | input | 2 | Per-lane A-to-B pass-through select |
| ba_pass | input | 2 | Per-lane B-to-A pass-through select |
| ab_en_n | input | 2 | Per-lane B-side drive enable, active low |
| ba_en_n | input | 2 | Per-lane A-side drive enable, active low |
| a_din | input | 16 | Data seen on the A side |
| b_din | input | 16 | Data seen on the B side |
| a_dout | output | 16 | Data driven toward the A side |
| a_oe | output | 16 | Per-bit drive enable for the A side |
| b_dout | output | 16 | Data driven toward the B side |
| b_oe | output | 16 | Per-bit drive enable for the B side |

## Verification
The enable outputs and the data outputs of passing paths must be correct in the same cycle as the stimulus. The bench drives inputs at the falling edge and samples 1 ns later, before the next rising edge. A stored output is due right after the rising edge that loads the register. The bench updates its own arithmetic copy of each register at that edge and compares at the following falling-edge sample. To cover R5, the bench changes the inputs again in mid-cycle and checks a second time before the edge.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
  typedef enum logic {
    PATH_STORED = 1'b0,
    PATH_PASS   = 1'b1
  } path_mode_e;

  function automatic logic drive_on(input logic global_n, input logic lane_n);
    return !global_n && !lane_n;
  endfunction
endpackage

// File: rtl/bxc_path.sv
module bxc_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pass,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  import bxc_pkg::*;

  logic [W-1:0] hold_q;
  path_mode_e   mode;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= din;
  end

  assign mode = pass ? PATH_PASS : PATH_STORED;

  always_comb begin
    case (mode)
      PATH_PASS: dout = din;
      default:   dout = hold_q;
    endcase
  end

  // R4
  stored_view_chk: assert property (@(posedge clk) disable iff (rst)
    (!pass && !$past(rst)) |-> dout == $past(din));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    ($past(rst) && !rst && !pass) |-> dout == '0);
endmodule

// File: rtl/bxc_lane.sv
module bxc_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         all_en_n,
  input  logic         ab_pass,
  input  logic         ba_pass,
  input  logic         ab_en_n,
  input  logic         ba_en_n,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] b_din,
  output logic [W-1:0] a_dout,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_dout,
  output logic [W-1:0] b_oe
);
  import bxc_pkg::*;

  bxc_path #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .pass(ab_pass), .din(a_din), .dout(b_dout)
  );

  bxc_path #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .pass(ba_pass), .din(b_din), .dout(a_dout)
  );

  assign b_oe = {W{drive_on(all_en_n, ab_en_n)}};
  assign a_oe = {W{drive_on(all_en_n, ba_en_n)}};

  // R7
  lane_b_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    (b_oe == '0) || (b_oe == '1));

  // R8
  lane_a_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    (a_oe == '0) || (a_oe == '1));
endmodule

// File: rtl/bus_xcvr16.sv
module bus_xcvr16 #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      all_en_n,
  input  logic [LANES-1:0]          ab_pass,
  input  logic [LANES-1:0]          ba_pass,
  input  logic [LANES-1:0]          ab_en_n,
  input  logic [LANES-1:0]          ba_en_n,
  input  logic [LANES*LANE_W-1:0]   a_din,
  input  logic [LANES*LANE_W-1:0]   b_din,
  output logic [LANES*LANE_W-1:0]   a_dout,
  output logic [LANES*LANE_W-1:0]   a_oe,
  output logic [LANES*LANE_W-1:0]   b_dout,
  output logic [LANES*LANE_W-1:0]   b_oe
);
  localparam int DW = LANES * LANE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    bxc_lane #(.W(LANE_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .all_en_n (all_en_n),
      .ab_pass  (ab_pass[i]),
      .ba_pass  (ba_pass[i]),
      .ab_en_n  (ab_en_n[i]),
      .ba_en_n  (ba_en_n[i]),
      .a_din    (a_din[i*LANE_W +: LANE_W]),
      .b_din    (b_din[i*LANE_W +: LANE_W]),
      .a_dout   (a_dout[i*LANE_W +: LANE_W]),
      .a_oe     (a_oe[i*LANE_W +: LANE_W]),
      .b_dout   (b_dout[i*LANE_W +: LANE_W]),
      .b_oe     (b_oe[i*LANE_W +: LANE_W])
    );
  end

  // R9
  global_off_chk: assert property (@(posedge clk) disable iff (rst)
    all_en_n |-> (a_oe == {DW{1'b0}} && b_oe == {DW{1'b0}}));
endmodule

// File: tb/bus_xcvr16_tb.sv
`timescale 1ns/1ps
module bus_xcvr16_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        all_en_n = 1'b1;
  logic [1:0]  ab_pass = '0, ba_pass = '0, ab_en_n = '1, ba_en_n = '1;
  logic [15:0] a_din = '0, b_din = '0;
  logic [15:0] a_dout, a_oe, b_dout, b_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] ref_ab, ref_ba;

  always #2 clk = ~clk;

  bus_xcvr16 u_dut (
    .clk(clk), .rst(rst), .all_en_n(all_en_n),
    .ab_pass(ab_pass), .ba_pass(ba_pass), .ab_en_n(ab_en_n), .ba_en_n(ba_en_n),
    .a_din(a_din), .b_din(b_din),
    .a_dout(a_dout), .a_oe(a_oe), .b_dout(b_dout), .b_oe(b_oe)
  );

  // bench copy of the registers: every rising edge loads, reset clears
  always @(posedge clk) begin
    if (rst) begin ref_ab <= '0; ref_ba <= '0; end
    else     begin ref_ab <= a_din; ref_ba <= b_din; end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string phase);
    for (int l = 0; l < 2; l++) begin
      logic [7:0] eb, ea, eob, eoa;
      eb  = ab_pass[l] ? a_din[l*8 +: 8] : ref_ab[l*8 +: 8];
      ea  = ba_pass[l] ? b_din[l*8 +: 8] : ref_ba[l*8 +: 8];
      eob = (!all_en_n && !ab_en_n[l]) ? 8'hFF : 8'h00;
      eoa = (!all_en_n && !ba_en_n[l]) ? 8'hFF : 8'h00;
      chk(ab_pass[l] ? {"R2 ", phase} : {"R4/R5 ", phase}, {8'h0, b_dout[l*8 +: 8]}, {8'h0, eb});
      chk(ba_pass[l] ? {"R3 ", phase} : {"R4/R5 ", phase}, {8'h0, a_dout[l*8 +: 8]}, {8'h0, ea});
      chk(all_en_n ? "R9 b_oe" : "R7 b_oe", {8'h0, b_oe[l*8 +: 8]}, {8'h0, eob});
      chk(all_en_n ? "R9 a_oe" : "R8 a_oe", {8'h0, a_oe[l*8 +: 8]}, {8'h0, eoa});
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    a_din = 16'h1234; b_din = 16'h5678;
    #1;
    // R10: registers cleared by reset, stored view shows zero
    chk("R10 b_dout", b_dout, 16'h0000);
    chk("R10 a_dout", a_dout, 16'h0000);

    // sweep of all control combinations
    for (int c = 0; c < 512; c++) begin
      @(negedge clk);
      {all_en_n, ab_en_n, ba_en_n, ab_pass, ba_pass} = 9'(c);
      a_din = 16'((c * 16'd977 + 16'd13) ^ (c << 7));
      b_din = 16'((c * 16'd613 + 16'd101) ^ (c >> 1));
      #1 check_all("edge");
      a_din = ~a_din;
      b_din = b_din + 16'h3C5A;
      #0.5 check_all("midcycle");
    end

    // R1: lane 1 passes, lane 0 stored; one lane's control does not leak
    @(negedge clk);
    all_en_n = 0; ab_pass = 2'b00; ab_en_n = 2'b01; a_din = 16'hAAAA;
    @(negedge clk);
    ab_pass = 2'b10; a_din = 16'h55CC;
    #1;
    chk("R1 lane split b_dout", b_dout, 16'h55AA);
    chk("R1 lane split b_oe", b_oe, 16'hFF00);

    // R6: b_din must not move b_dout, a_din must not move a_dout
    ab_pass = 2'b00; ba_pass = 2'b00;
    @(negedge clk);
    a_din = 16'h0F0F; b_din = 16'hF00F;
    @(negedge clk);
    b_din = 16'h1111; a_din = 16'h0F0F;
    @(negedge clk);
    a_din = 16'h2222;
    #1;
    chk("R6 b_dout isolated from b_din", b_dout, 16'h0F0F);
    chk("R6 a_dout isolated from a_din", a_dout, 16'h1111);

    // R11: register loads while passing; falling pass shows last edge value
    ab_pass = 2'b11; a_din = 16'hBEEF;
    @(negedge clk);
    a_din = 16'hC0DE;
    #0.5 ab_pass = 2'b00;
    #0.5;
    chk("R11 last edge value", b_dout, 16'hBEEF);

    // R10 again: reset mid-run clears stored data
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; ab_pass = 2'b00; ba_pass = 2'b00;
    #1;
    chk("R10 reset clears b", b_dout, 16'h0000);
    chk("R10 reset clears a", a_dout, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule